// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs single accesses to external code and data memory over a narrow multiplexed bus. The lower address byte and the data byte share one 8-bit bus (`ad_out`/`ad_in` with the drive enable `ad_oe`). The upper address byte has its own output, `addr_hi`, which holds its value for the whole access. An external latch captures the low byte while the address strobe `ale` is high. After that, one of three active-low strobes moves the data: `psen_n` for code fetches, `rd_n` for data reads and `wr_n` for data writes. One clock period of the block equals one oscillator period, and every bus phase is a fixed number of those periods.

The internal side is a single request port. A one-cycle `req_valid` carries a kind code, a 16-bit address and write data. The block answers with a one-period `done` pulse and, for reads and fetches, the captured byte on `rdata`. A slow device can hold `rdy_in` low to lengthen the strobe in whole periods. While `code_ext_n` is high, a code fetch below the internal code-space limit never reaches the bus and is answered with `int_hit`, so the core can serve it from on-chip storage. While reset is asserted, `float_sel` chooses between driving the four control outputs high and releasing them through `ctl_oe`.

Top module: `xbus_ctrl`

## Requirements
- R1: After a request is accepted, `ale` is high for exactly 3 periods. During those periods `ad_oe` is 1 and `ad_out` carries address bits 7:0. `addr_hi` carries address bits 15:8 from the first ALE period until at least the `done` period.
- R2: In the single period after `ale` falls, `ad_out` still carries the low address with `ad_oe` = 1 and no strobe is active. The strobe asserts in the following period and is never active at the same time as `ale`.
- R3: The kind code selects the strobe: 0 = fetch uses `psen_n`, 2 = write uses `wr_n`, and 1 or 3 = read uses `rd_n`. With `rdy_in` high, the strobe is low for exactly 4 periods. At most one strobe is low at any time.
- R4: For fetches and reads, `ad_oe` is 0 for the whole strobe. `ad_in` is captured at the clock edge that releases the strobe and appears on `rdata` in the `done` period.
- R5: For writes, `ad_oe` is 0 in the first strobe period. From the second strobe period `ad_out` carries the write data with `ad_oe` = 1, and it stays driven for one period after `wr_n` returns high.
- R6: `rdy_in` is sampled at the clock edge that closes the last nominal strobe period, and again at each later edge while the strobe is stretched. Each low sample lengthens the strobe by one period. The first high sample releases it.
- R7: `done` is high for exactly one period. That period comes two periods after the strobe is released, and no strobe and no `ale` is active during it.
- R8: A fetch with `code_ext_n` = 1 and an address below 0x3000 starts no bus cycle. `done` and `int_hit` rise together in the next period. A fetch at 0x3000 or above, any fetch with `code_ext_n` = 0, and any read go to the bus.
- R9: A request presented while an access is in progress is ignored. `addr_hi` keeps the accepted address, and no new ALE follows the `done` period.
- R10: While `rst` is high, `ctl_oe` follows `float_sel`. After the first clock edge in reset, `ale`, `psen_n`, `rd_n` and `wr_n` are all 1 and `ad_oe` is 0.
- R11: When idle after reset, `ale` = 0, all strobes are 1, `ad_oe` = 0 and `ctl_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-period access request |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| code_ext_n | input | 1 | Low forces every fetch onto the external bus |
| done | output | 1 | One-period completion pulse |
| int_hit | output | 1 | With done: the fetch targets internal code space |
| rdata | output | 8 | Captured read or instruction byte |
| rdy_in | input | 1 | External ready; low stretches the strobe |
| float_sel | input | 1 | Reset-time choice: 1 drive controls high, 0 release them |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ctl_oe | output | 1 | Output enable for ale, psen_n, rd_n and wr_n |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared bus output: low address or write data |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 8 | Shared bus input |

## Verification
The bench goes after the READY sample point. A design that samples one edge early or late produces a strobe that is off by a period, or one that ignores a low sample. Near the internal code-space limit it fetches at 0x2FFF and at 0x3000. A wrong compare would either skip a real bus fetch or put an internal fetch on the bus. It changes `ad_in` just after the strobe is released, so a capture taken one edge late returns the wrong byte. It also checks the idle period before write data is driven and the hold period after `wr_n` rises; a design that got these wrong would fight the read driver or drop the data before the device latches it. Finally, it issues a request in the middle of an access; a controller that accepted it would change `addr_hi` or start a second ALE.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_HOLD,
    ST_STB,
    ST_TAIL
  } bus_st_e;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
  parameter int ADDR_W        = 16,
  parameter int BYTE_W        = 8,
  parameter int CNT_W         = 3,
  parameter int ALE_CYC       = 3,
  parameter int LA_HOLD       = 1,
  parameter int STB_CYC       = 4,
  parameter int DH_CYC        = 1,
  parameter int INT_CODE_SIZE = 12288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              code_ext_n,
  input  logic              rdy_in,
  output bus_st_e           nxt_st,
  output logic [CNT_W-1:0]  nxt_cnt,
  output acc_kind_e         nxt_kind,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [BYTE_W-1:0] nxt_wdata,
  output logic              start,
  output logic              cap,
  output logic              fin,
  output logic              int_fin
);
  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYC - 1);
  localparam logic [CNT_W-1:0] HLD_LAST = CNT_W'(LA_HOLD - 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] DH_LAST  = CNT_W'(DH_CYC - 1);
  localparam logic [ADDR_W:0]  ROM_LIM  = (ADDR_W+1)'(INT_CODE_SIZE);

  bus_st_e           st;
  logic [CNT_W-1:0]  cnt;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              is_internal;

  assign is_internal = (req_kind == 2'd0) && code_ext_n &&
                       ({1'b0, req_addr} < ROM_LIM);

  always_comb begin
    nxt_st    = st;
    nxt_cnt   = cnt;
    nxt_kind  = kind_q;
    nxt_addr  = addr_q;
    nxt_wdata = wdata_q;
    start     = 1'b0;
    cap       = 1'b0;
    fin       = 1'b0;
    int_fin   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          if (is_internal) begin
            int_fin = 1'b1;
          end else begin
            start     = 1'b1;
            nxt_st    = ST_ALE;
            nxt_cnt   = '0;
            nxt_kind  = acc_kind_e'((req_kind == 2'd3) ? 2'd1 : req_kind);
            nxt_addr  = req_addr;
            nxt_wdata = req_wdata;
          end
        end
      end
      ST_ALE: begin
        if (cnt == ALE_LAST) begin
          nxt_st  = ST_HOLD;
          nxt_cnt = '0;
        end else begin
          nxt_cnt = cnt + CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cnt == HLD_LAST) begin
          nxt_st  = ST_STB;
          nxt_cnt = '0;
        end else begin
          nxt_cnt = cnt + CNT_W'(1);
        end
      end
      ST_STB: begin
        if (cnt == STB_LAST) begin
          if (rdy_in) begin
            nxt_st  = ST_TAIL;
            nxt_cnt = '0;
            cap     = (kind_q != K_WRITE);
          end
        end else begin
          nxt_cnt = cnt + CNT_W'(1);
        end
      end
      ST_TAIL: begin
        if (cnt == DH_LAST) begin
          nxt_st  = ST_IDLE;
          nxt_cnt = '0;
          fin     = 1'b1;
        end else begin
          nxt_cnt = cnt + CNT_W'(1);
        end
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      kind_q  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st      <= nxt_st;
      cnt     <= nxt_cnt;
      kind_q  <= nxt_kind;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
    end
  end

  // R9
  busy_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins import xbus_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3,
  parameter int WD_LAG = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  bus_st_e                  nxt_st,
  input  logic [CNT_W-1:0]         nxt_cnt,
  input  acc_kind_e                nxt_kind,
  input  logic [ADDR_W-1:0]        nxt_addr,
  input  logic [BYTE_W-1:0]        nxt_wdata,
  input  logic                     start,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [BYTE_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-BYTE_W-1:0] addr_hi
);
  localparam logic [CNT_W-1:0] LAG_C = CNT_W'(WD_LAG);

  logic strobe_on;
  logic addr_phase;
  logic wr_drive;

  always_comb begin
    strobe_on  = (nxt_st == ST_STB);
    addr_phase = (nxt_st == ST_ALE) || (nxt_st == ST_HOLD);
    wr_drive   = (nxt_kind == K_WRITE) &&
                 ((strobe_on && (nxt_cnt >= LAG_C)) || (nxt_st == ST_TAIL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b1;
      psen_n  <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      addr_hi <= '0;
    end else begin
      ale    <= (nxt_st == ST_ALE);
      psen_n <= !(strobe_on && (nxt_kind == K_FETCH));
      rd_n   <= !(strobe_on && (nxt_kind == K_READ));
      wr_n   <= !(strobe_on && (nxt_kind == K_WRITE));
      ad_oe  <= addr_phase || wr_drive;
      if (addr_phase)    ad_out <= nxt_addr[BYTE_W-1:0];
      else if (wr_drive) ad_out <= nxt_wdata;
      if (start) addr_hi <= nxt_addr[ADDR_W-1:BYTE_W];
    end
  end

  // R2
  ale_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe);
endmodule

// File: rtl/xbus_resp.sv
module xbus_resp #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              fin,
  input  logic              int_fin,
  input  logic [BYTE_W-1:0] ad_in,
  output logic [BYTE_W-1:0] rdata,
  output logic              done,
  output logic              int_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      done    <= 1'b0;
      int_hit <= 1'b0;
    end else begin
      if (cap) rdata <= ad_in;
      done    <= fin || int_fin;
      int_hit <= int_fin;
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl import xbus_pkg::*; #(
  parameter int ADDR_W        = 16,
  parameter int BYTE_W        = 8,
  parameter int ALE_CYC       = 3,
  parameter int LA_HOLD       = 1,
  parameter int STB_CYC       = 4,
  parameter int WD_LAG        = 1,
  parameter int DH_CYC        = 1,
  parameter int INT_CODE_SIZE = 12288
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [BYTE_W-1:0]        req_wdata,
  input  logic                     code_ext_n,
  output logic                     done,
  output logic                     int_hit,
  output logic [BYTE_W-1:0]        rdata,
  input  logic                     rdy_in,
  input  logic                     float_sel,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     ctl_oe,
  output logic [ADDR_W-BYTE_W-1:0] addr_hi,
  output logic [BYTE_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [BYTE_W-1:0]        ad_in
);
  localparam int M1    = (ALE_CYC > LA_HOLD) ? ALE_CYC : LA_HOLD;
  localparam int M2    = (STB_CYC > DH_CYC) ? STB_CYC : DH_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXP  = (M3 > WD_LAG) ? M3 : WD_LAG;
  localparam int CNT_W = $clog2(MAXP + 1);

  bus_st_e           nxt_st;
  logic [CNT_W-1:0]  nxt_cnt;
  acc_kind_e         nxt_kind;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BYTE_W-1:0] nxt_wdata;
  logic              start, cap, fin, int_fin;

  assign ctl_oe = rst ? float_sel : 1'b1;

  xbus_seq #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .ALE_CYC(ALE_CYC),
    .LA_HOLD(LA_HOLD), .STB_CYC(STB_CYC), .DH_CYC(DH_CYC),
    .INT_CODE_SIZE(INT_CODE_SIZE)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .code_ext_n(code_ext_n),
    .rdy_in(rdy_in), .nxt_st(nxt_st), .nxt_cnt(nxt_cnt), .nxt_kind(nxt_kind),
    .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata), .start(start), .cap(cap),
    .fin(fin), .int_fin(int_fin)
  );

  xbus_pins #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .WD_LAG(WD_LAG)
  ) u_pins (
    .clk(clk), .rst(rst), .nxt_st(nxt_st), .nxt_cnt(nxt_cnt),
    .nxt_kind(nxt_kind), .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
    .start(start), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi)
  );

  xbus_resp #(.BYTE_W(BYTE_W)) u_resp (
    .clk(clk), .rst(rst), .cap(cap), .fin(fin), .int_fin(int_fin),
    .ad_in(ad_in), .rdata(rdata), .done(done), .int_hit(int_hit)
  );

  // R6
  ready_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(psen_n) || $rose(rd_n) || $rose(wr_n)) |-> $past(rdy_in));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (psen_n && rd_n && wr_n && !ale));
endmodule

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        code_ext_n;
  logic        done, int_hit;
  logic [7:0]  rdata;
  logic        rdy_in, float_sel;
  logic        ale, psen_n, rd_n, wr_n, ctl_oe;
  logic [7:0]  addr_hi, ad_out, ad_in;
  logic        ad_oe;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .code_ext_n(code_ext_n),
    .done(done), .int_hit(int_hit), .rdata(rdata), .rdy_in(rdy_in),
    .float_sel(float_sel), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ctl_oe(ctl_oe), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in)
  );

  // {kind[2], ext_n[1], ready_low_count[4], pad[1], addr[16], wdata[8], bus_in[8]}
  localparam int N_VEC = 9;
  localparam logic [39:0] VEC [N_VEC] = '{
    {2'd0, 1'b0, 4'd0, 1'b0, 16'h1234, 8'h00, 8'hA5},
    {2'd0, 1'b1, 4'd0, 1'b0, 16'h1234, 8'h00, 8'h11},
    {2'd0, 1'b1, 4'd0, 1'b0, 16'h3000, 8'h00, 8'h6B},
    {2'd0, 1'b1, 4'd0, 1'b0, 16'h2FFF, 8'h00, 8'h22},
    {2'd1, 1'b0, 4'd0, 1'b0, 16'hBEEF, 8'h00, 8'h3C},
    {2'd1, 1'b0, 4'd2, 1'b0, 16'h00FF, 8'h00, 8'hC3},
    {2'd2, 1'b0, 4'd0, 1'b0, 16'h8001, 8'h5A, 8'h00},
    {2'd2, 1'b0, 4'd3, 1'b0, 16'hFFFF, 8'hA5, 8'h00},
    {2'd3, 1'b1, 4'd1, 1'b0, 16'h0010, 8'h00, 8'h7E}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [1:0] k, input logic extn, input int nlow,
                            input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] din, input bit poke);
    logic       internal;
    logic [2:0] exp_stb;
    internal = (k == 2'd0) && extn && (a < 16'h3000);
    exp_stb  = (k == 2'd0) ? 3'b011 : ((k == 2'd2) ? 3'b110 : 3'b101);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    code_ext_n = extn; ad_in = din; rdy_in = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (internal) begin
      chk("R8 done", done, 1);
      chk("R8 int_hit", int_hit, 1);
      chk("R8 ale", ale, 0);
      chk("R8 strobes", {psen_n, rd_n, wr_n}, 3'b111);
      chk("R8 ad_oe", ad_oe, 0);
      @(negedge clk);
      chk("R7 done width", done, 0);
      chk("R8 no ale", ale, 0);
      return;
    end
    for (int i = 0; i < 3; i++) begin
      chk("R1 ale high", ale, 1);
      chk("R1 ad_oe", ad_oe, 1);
      chk("R1 low addr", ad_out, a[7:0]);
      chk("R1 high addr", addr_hi, a[15:8]);
      chk("R2 no strobe in ale", {psen_n, rd_n, wr_n}, 3'b111);
      @(negedge clk);
    end
    chk("R2 ale low", ale, 0);
    chk("R2 addr hold oe", ad_oe, 1);
    chk("R2 addr hold", ad_out, a[7:0]);
    chk("R2 no strobe yet", {psen_n, rd_n, wr_n}, 3'b111);
    @(negedge clk);
    for (int j = 0; j < 4 + nlow; j++) begin
      chk("R3/R6 strobe", {psen_n, rd_n, wr_n}, exp_stb);
      chk("R1 high addr kept", addr_hi, a[15:8]);
      chk("R2 ale off", ale, 0);
      if (k == 2'd2) begin
        chk("R5 write oe", ad_oe, (j >= 1) ? 1 : 0);
        if (j >= 1) chk("R5 write data", ad_out, wd);
      end else begin
        chk("R4 bus released", ad_oe, 0);
      end
      if (poke && j == 1) begin
        req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h5555;
      end else begin
        req_valid = 1'b0;
      end
      rdy_in = !(j >= 3 && j < 3 + nlow);
      @(negedge clk);
    end
    rdy_in = 1'b1;
    req_valid = 1'b0;
    chk("R3/R6 strobe released", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R7 done not yet", done, 0);
    if (k == 2'd2) begin
      chk("R5 data hold oe", ad_oe, 1);
      chk("R5 data hold", ad_out, wd);
    end else begin
      chk("R4 tail oe", ad_oe, 0);
    end
    ad_in = ~din;
    @(negedge clk);
    chk("R7 done", done, 1);
    chk("R8 int_hit low", int_hit, 0);
    if (k != 2'd2) chk("R4 rdata", rdata, din);
    chk("R11 oe idle", ad_oe, 0);
    chk("R9 high addr", addr_hi, a[15:8]);
    @(negedge clk);
    chk("R7 done width", done, 0);
    if (poke) begin
      chk("R9 no new ale", ale, 0);
      chk("R9 no strobe", {psen_n, rd_n, wr_n}, 3'b111);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; float_sel = 1'b1; req_valid = 1'b0; req_kind = 2'd0;
    req_addr = 16'h0; req_wdata = 8'h0; code_ext_n = 1'b0; rdy_in = 1'b1;
    ad_in = 8'h0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 ctl_oe drive", ctl_oe, 1);
    chk("R10 ale high", ale, 1);
    chk("R10 strobes high", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R10 ad_oe", ad_oe, 0);
    float_sel = 1'b0;
    #1;
    chk("R10 ctl_oe float", ctl_oe, 0);
    float_sel = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ale idle", ale, 0);
    chk("R11 strobes idle", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R11 ad_oe idle", ad_oe, 0);
    chk("R11 ctl_oe", ctl_oe, 1);
    chk("R11 done idle", done, 0);

    for (int v = 0; v < N_VEC; v++) begin
      run_access(VEC[v][39:38], VEC[v][37], int'(VEC[v][36:33]),
                 VEC[v][31:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
    end

    // R9: request during a busy access is dropped
    run_access(2'd1, 1'b0, 0, 16'h4321, 8'h00, 8'h99, 1'b1);
    // R6: long stretch on a fetch
    run_access(2'd0, 1'b0, 5, 16'hC0DE, 8'h00, 8'h5E, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule